// File: doc/BRIEF.md
# Boundary Event Arbiter for Non-Maskable and System-Management Interrupts

This block chooses which asynchronous processor event, if any, is taken at each instruction boundary. Four sources compete: a system-management interrupt, a non-maskable interrupt, a debug exception and a maskable interrupt. When the core asserts its boundary strobe, the block raises exactly one one-cycle take pulse for the winning event. No take pulse is raised when nothing is eligible. The take outputs are combinational from the current state and the strobe, so the core sees the decision in the strobe cycle itself.

Alongside the choice, the block keeps the state that decides eligibility. It holds a management-mode residency flag and a non-maskable blocking flag. It also holds a one-deep pending latch for each edge-triggered source, so a request that arrives while it cannot be taken is kept rather than lost. Retire pulses for the interrupt-return and the resume-from-management-mode instructions move this state. The blocking flag is not saved separately when management mode is entered. Instead, a shadow copy records whether blocking should come back on resume. Any interrupt-return inside management mode clears both the live flag and that shadow copy. As a result, a non-maskable event can nest inside a handler that has not yet finished.

All pins are plain control and status signals. There is no data stream, so no valid/ready handshake applies.

Top module: `evt_arbiter`

## Requirements
- R1: Take outputs change only while `boundary_i` is high. At most one of the four take outputs is high in any cycle.
- R2: The take vector {intr, dbg, nmi, smi} (bit 0 = management interrupt, bit 3 = maskable interrupt) gives fixed priority: management interrupt, then non-maskable, then debug, then maskable. With several sources eligible at one boundary, only the highest is taken.
- R3: A rising edge on `nmi_i` makes one request, visible from the next cycle. Holding the line high makes no further request.
- R4: Taking a non-maskable event sets `nmi_blocked_o`. While the flag is set, one further request is held in `nmi_pending_o` and extra requests are dropped. A retired interrupt-return clears the flag, and the held request is then taken.
- R5: Taking a management interrupt sets `in_smm_o` and `nmi_blocked_o` from the next cycle. A retired resume clears `in_smm_o`.
- R6: Non-maskable requests that arrive during management mode while blocked are latched at most once. If blocking was clear when the management interrupt was taken, the latched request is taken at the first boundary after resume.
- R7: A rising edge on `smi_i` is captured into `smi_pending_o`. It is never taken while `in_smm_o` is set, at most one is held, and after resume it is taken ahead of a latched non-maskable request.
- R8: An interrupt-return retired inside management mode clears `nmi_blocked_o`, so a non-maskable event can be taken inside management mode. After resume, blocking is then clear even if it was set before entry, which allows nesting.
- R9: If blocking was set when the management interrupt was taken and no interrupt-return retired inside management mode, `nmi_blocked_o` is set again after resume.
- R10: The maskable interrupt is taken only when `intr_en_i` is high and `in_smm_o` is low.
- R11: After reset, `in_smm_o`, `nmi_blocked_o`, `nmi_pending_o` and `smi_pending_o` are 0, and a boundary with no request takes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_i | input | 1 | Management interrupt line, rising-edge captured |
| nmi_i | input | 1 | Non-maskable interrupt line, rising-edge captured |
| dbg_i | input | 1 | Debug exception request, level |
| intr_i | input | 1 | Maskable interrupt request, level |
| intr_en_i | input | 1 | Maskable interrupt enable |
| boundary_i | input | 1 | Instruction-boundary strobe |
| iret_ret_i | input | 1 | Interrupt-return retired pulse |
| rsm_ret_i | input | 1 | Resume-from-management-mode retired pulse |
| take_smi_o | output | 1 | Management interrupt taken this cycle |
| take_nmi_o | output | 1 | Non-maskable interrupt taken this cycle |
| take_dbg_o | output | 1 | Debug exception taken this cycle |
| take_intr_o | output | 1 | Maskable interrupt taken this cycle |
| in_smm_o | output | 1 | Management-mode residency |
| nmi_blocked_o | output | 1 | Non-maskable blocking flag |
| nmi_pending_o | output | 1 | Latched non-maskable request |
| smi_pending_o | output | 1 | Latched management interrupt request |

## Verification
The assertions assume the core sends a resume pulse only while it is in management mode. They also assume a retire pulse and a take of the same kind never fall in the same cycle. The stimulus meets both conditions by always driving retire pulses in cycles with the boundary strobe low. It also pulses resume only after a management interrupt has been taken. Request lines are kept low through reset, so no edge is seen as reset is released.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;
  localparam int EV_SMI   = 0;
  localparam int EV_NMI   = 1;
  localparam int EV_DBG   = 2;
  localparam int EV_INTR  = 3;
  localparam int EV_COUNT = 4;
  localparam int EDGE_SRC = 2;
  localparam int ES_SMI   = 0;
  localparam int ES_NMI   = 1;
  typedef logic [EV_COUNT-1:0] ev_vec_t;
endpackage

// File: rtl/evt_edge_latch.sv
module evt_edge_latch #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] taken_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] lvl_q;

  for (genvar gi = 0; gi < W; gi++) begin : g_src
    logic rise;
    assign rise = lvl_i[gi] & ~lvl_q[gi];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl_q[gi]  <= 1'b0;
        pend_o[gi] <= 1'b0;
      end else begin
        lvl_q[gi]  <= lvl_i[gi];
        pend_o[gi] <= rise | (pend_o[gi] & ~taken_i[gi]);
      end
    end

    // R3: a pending request disappears only through a take
    p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[gi] && !taken_i[gi] |=> pend_o[gi]);
  end
endmodule

// File: rtl/evt_priority_pick.sv
module evt_priority_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_pick
    if (gi == 0) begin : g_top
      assign grant_o[gi] = req_i[gi];
    end else begin : g_rest
      assign grant_o[gi] = req_i[gi] & ~(|req_i[gi-1:0]);
    end
  end

  always_comb begin
    p_grant_onehot_r1: assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/evt_state_track.sv
module evt_state_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take_smi_i,
  input  logic take_nmi_i,
  input  logic iret_i,
  input  logic rsm_i,
  output logic in_smm_o,
  output logic nmi_blk_o
);
  logic shadow_blk;
  logic rsm_eff;

  assign rsm_eff = rsm_i & in_smm_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_smm_o   <= 1'b0;
      nmi_blk_o  <= 1'b0;
      shadow_blk <= 1'b0;
    end else begin
      if (take_smi_i) begin
        in_smm_o   <= 1'b1;
        nmi_blk_o  <= 1'b1;
        shadow_blk <= nmi_blk_o;
      end else if (rsm_eff) begin
        in_smm_o  <= 1'b0;
        nmi_blk_o <= shadow_blk & ~iret_i;
      end else if (take_nmi_i) begin
        nmi_blk_o <= 1'b1;
      end else if (iret_i) begin
        nmi_blk_o <= 1'b0;
        if (in_smm_o) shadow_blk <= 1'b0;
      end
    end
  end

  // R5: management entry raises residency and blocking
  p_smm_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_smi_i |=> in_smm_o && nmi_blk_o);
  // R5: resume leaves management mode
  p_smm_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_smm_o && rsm_i && !take_smi_i |=> !in_smm_o);
  // R4: a non-maskable take raises blocking
  p_nmi_sets_blk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_i && !rsm_eff |=> nmi_blk_o);
  // R8: interrupt-return in management mode clears blocking
  p_iret_smm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_smm_o && iret_i && !take_nmi_i && !take_smi_i && !rsm_i |=> !nmi_blk_o);
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import evt_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smi_i,
  input  logic nmi_i,
  input  logic dbg_i,
  input  logic intr_i,
  input  logic intr_en_i,
  input  logic boundary_i,
  input  logic iret_ret_i,
  input  logic rsm_ret_i,
  output logic take_smi_o,
  output logic take_nmi_o,
  output logic take_dbg_o,
  output logic take_intr_o,
  output logic in_smm_o,
  output logic nmi_blocked_o,
  output logic nmi_pending_o,
  output logic smi_pending_o
);
  logic [EDGE_SRC-1:0] edge_lvl, edge_taken, edge_pend;
  ev_vec_t elig, grant;
  logic in_smm, nmi_blk;

  assign edge_lvl[ES_SMI]   = smi_i;
  assign edge_lvl[ES_NMI]   = nmi_i;
  assign edge_taken[ES_SMI] = grant[EV_SMI];
  assign edge_taken[ES_NMI] = grant[EV_NMI];

  evt_edge_latch #(.W(EDGE_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .lvl_i(edge_lvl),
    .taken_i(edge_taken), .pend_o(edge_pend)
  );

  always_comb begin
    elig          = '0;
    elig[EV_SMI]  = boundary_i & edge_pend[ES_SMI] & ~in_smm;
    elig[EV_NMI]  = boundary_i & edge_pend[ES_NMI] & ~nmi_blk;
    elig[EV_DBG]  = boundary_i & dbg_i;
    elig[EV_INTR] = boundary_i & intr_i & intr_en_i & ~in_smm;
  end

  evt_priority_pick #(.N(EV_COUNT)) u_pick (.req_i(elig), .grant_o(grant));

  evt_state_track u_state (
    .clk(clk), .rst_n(rst_n),
    .take_smi_i(grant[EV_SMI]), .take_nmi_i(grant[EV_NMI]),
    .iret_i(iret_ret_i), .rsm_i(rsm_ret_i),
    .in_smm_o(in_smm), .nmi_blk_o(nmi_blk)
  );

  assign take_smi_o    = grant[EV_SMI];
  assign take_nmi_o    = grant[EV_NMI];
  assign take_dbg_o    = grant[EV_DBG];
  assign take_intr_o   = grant[EV_INTR];
  assign in_smm_o      = in_smm;
  assign nmi_blocked_o = nmi_blk;
  assign nmi_pending_o = edge_pend[ES_NMI];
  assign smi_pending_o = edge_pend[ES_SMI];

  // R1: no take without a boundary
  p_take_at_bnd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take_smi_o || take_nmi_o || take_dbg_o || take_intr_o) |-> boundary_i);
  // R1: one take at most
  p_take_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_intr_o, take_dbg_o, take_nmi_o, take_smi_o}));
  // R7: no management interrupt while resident
  p_no_smi_in_smm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_smm_o |-> !take_smi_o);
  // R10: no maskable interrupt while resident
  p_no_intr_in_smm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_smm_o |-> !take_intr_o);
  // R4: non-maskable take only when unblocked
  p_nmi_unblocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_o |-> !nmi_blocked_o);
endmodule

// File: tb/test_evt_arbiter.sv
module test_evt_arbiter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smi = 0, nmi = 0, dbg = 0, intr = 0, intr_en = 0, bnd = 0, iret = 0, rsm = 0;
  logic t_smi, t_nmi, t_dbg, t_intr, smm, blk, npend, spend;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_arbiter i_evt_arbiter (
    .clk(clk), .rst_n(rst_n), .smi_i(smi), .nmi_i(nmi), .dbg_i(dbg),
    .intr_i(intr), .intr_en_i(intr_en), .boundary_i(bnd),
    .iret_ret_i(iret), .rsm_ret_i(rsm),
    .take_smi_o(t_smi), .take_nmi_o(t_nmi), .take_dbg_o(t_dbg),
    .take_intr_o(t_intr), .in_smm_o(smm), .nmi_blocked_o(blk),
    .nmi_pending_o(npend), .smi_pending_o(spend)
  );

  function automatic logic [3:0] takes();
    return {t_intr, t_dbg, t_nmi, t_smi};
  endfunction

  task automatic chk4(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // boundary strobe for one cycle, take vector checked inside it
  task automatic boundary(input string req, input logic [3:0] exp);
    @(negedge clk); bnd = 1'b1;
    #1 chk4(req, takes(), exp);
    @(negedge clk); bnd = 1'b0;
  endtask

  // status {smi_pending, nmi_pending, blocked, in_smm}
  task automatic status(input string req, input logic [3:0] exp);
    @(negedge clk);
    #1 chk4(req, {spend, npend, blk, smm}, exp);
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); nmi = 1'b0;
  endtask
  task automatic pulse_smi();
    @(negedge clk); smi = 1'b1;
    @(negedge clk); smi = 1'b0;
  endtask
  task automatic pulse_iret();
    @(negedge clk); iret = 1'b1;
    @(negedge clk); iret = 1'b0;
  endtask
  task automatic pulse_rsm();
    @(negedge clk); rsm = 1'b1;
    @(negedge clk); rsm = 1'b0;
  endtask

  task automatic t_reset();
    status("R11 reset status", 4'b0000);
    boundary("R11 idle boundary", 4'b0000);
  endtask

  task automatic t_boundary_only();
    pulse_nmi();
    #1 chk4("R1 no take without boundary", takes(), 4'b0000);
    boundary("R1 nmi at boundary", 4'b0010);
    pulse_iret();
  endtask

  task automatic t_level_held();
    @(negedge clk); nmi = 1'b1;
    boundary("R3 first edge taken", 4'b0010);
    pulse_iret();
    boundary("R3 held level no repeat", 4'b0000);
    @(negedge clk); nmi = 1'b0;
  endtask

  task automatic t_priority();
    @(negedge clk); smi = 1'b1; nmi = 1'b1; dbg = 1'b1; intr = 1'b1; intr_en = 1'b1;
    @(negedge clk); smi = 1'b0; nmi = 1'b0;
    boundary("R2 smi wins", 4'b0001);
    pulse_rsm();
    boundary("R2 nmi over dbg", 4'b0010);
    pulse_iret();
    boundary("R2 dbg over intr", 4'b0100);
    @(negedge clk); dbg = 1'b0;
    boundary("R2 intr last", 4'b1000);
    @(negedge clk); intr_en = 1'b0;
    boundary("R10 intr disabled", 4'b0000);
    @(negedge clk); intr = 1'b0;
  endtask

  task automatic t_nmi_block();
    pulse_nmi();
    boundary("R4 nmi taken", 4'b0010);
    pulse_nmi();
    pulse_nmi();
    boundary("R4 blocked no take", 4'b0000);
    status("R4 one held while blocked", 4'b0110);
    pulse_iret();
    boundary("R4 held nmi after iret", 4'b0010);
    pulse_iret();
    boundary("R4 extra request dropped", 4'b0000);
  endtask

  task automatic t_smm_latch();
    pulse_smi();
    boundary("R5 smi taken", 4'b0001);
    status("R5 in smm blocked", 4'b0011);
    @(negedge clk); intr = 1'b1; intr_en = 1'b1;
    pulse_nmi(); pulse_nmi(); pulse_smi(); pulse_smi();
    boundary("R10 no intr in smm", 4'b0000);
    @(negedge clk); intr = 1'b0;
    status("R7 both latched in smm", 4'b1111);
    pulse_rsm();
    status("R5 resume exits smm", 4'b1100);
    boundary("R7 latched smi first", 4'b0001);
    pulse_rsm();
    boundary("R6 latched nmi after resume", 4'b0010);
    pulse_iret();
    boundary("R6 R7 single latch each", 4'b0000);
    @(negedge clk); intr_en = 1'b0;
  endtask

  task automatic t_iret_in_smm();
    pulse_nmi();
    boundary("R8 outer nmi", 4'b0010);
    pulse_smi();
    boundary("R8 smi inside handler", 4'b0001);
    pulse_iret();
    status("R8 iret in smm unblocks", 4'b0001);
    pulse_nmi();
    boundary("R8 nmi inside smm", 4'b0010);
    pulse_rsm();
    status("R8 unblocked after resume", 4'b0000);
    pulse_nmi();
    boundary("R8 nested nmi", 4'b0010);
    pulse_iret();
  endtask

  task automatic t_block_restored();
    pulse_nmi();
    boundary("R9 outer nmi", 4'b0010);
    pulse_smi();
    boundary("R9 smi taken", 4'b0001);
    pulse_nmi();
    pulse_rsm();
    status("R9 blocking restored", 4'b0110);
    boundary("R9 no nest", 4'b0000);
    pulse_iret();
    boundary("R9 nmi after iret", 4'b0010);
    pulse_iret();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_boundary_only();
    t_level_held();
    t_priority();
    t_nmi_block();
    t_smm_latch();
    t_iret_in_smm();
    t_block_restored();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule